// File: doc/BRIEF.md
# Operand Effective Address Generator

This block resolves one instruction operand into a location. It takes a 3-bit addressing-mode code, a register number, a signed constant and an operand size. It reads the register file value for that register and the program counter, both supplied by the surrounding pipeline. From these it decides whether the operand is an immediate value, a register or a memory location. For memory operands it computes the effective address.

The two pointer-walking modes change the register they use. Post-increment addresses through the current pointer and then advances it. Pre-decrement steps the pointer back first and then addresses through the new value. In both cases the block emits a register write-back request that carries the updated pointer. The step is the operand size in bytes.

All results are registered. An operand accepted on one clock edge appears on the outputs for exactly the following cycle. While no input is offered, the valid and write-back strobes stay low.

Top module: `operand_ea_gen`

## Requirements
- R1: After reset, `res_valid`, `wb_en`, `res_kind`, `res_addr`, `res_value`, `wb_idx` and `wb_value` are all zero.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `res_valid` high on the next cycle. A cycle with `in_valid` low produces `res_valid` and `wb_en` low on the next cycle.
- R3: Mode 0 (immediate) gives kind 0, `res_value` equal to the sign-extended constant, and `res_addr` 0.
- R4: Mode 1 (register) gives kind 1, `res_value` equal to the register content, and `res_addr` 0.
- R5: Mode 2 (direct) gives kind 2, with `res_addr` equal to the sign-extended constant.
- R6: Mode 3 (indirect) gives kind 2, with `res_addr` equal to the register content.
- R7: Mode 4 (index) gives kind 2, with `res_addr` equal to register content plus the sign-extended constant, modulo 2^32.
- R8: Mode 5 (post-increment) gives kind 2, with `res_addr` equal to the register content. It also writes back register content plus step to the same register.
- R9: Mode 6 (pre-decrement) gives kind 2, with `res_addr` equal to register content minus step. It writes back that same value to the same register.
- R10: Mode 7 (relative) gives kind 2, with `res_addr` equal to `pc` plus the sign-extended constant, modulo 2^32.
- R11: The step depends on `op_size`: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.
- R12: `wb_en` is high only in the result cycle of an accepted mode-5 or mode-6 operand. In every other case it is low.
- R13: For kinds 1 and 2, `res_value` is 0 in memory modes. `wb_idx` equals the register number whenever `wb_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand request offered this cycle |
| in_mode | input | 3 | Addressing-mode code (0..7) |
| in_reg | input | 4 | Register number |
| in_const | input | 16 | Signed constant field |
| op_size | input | 2 | Operand size code (1, 2, 4 bytes) |
| reg_rdata | input | 32 | Register file content for `in_reg` |
| pc | input | 32 | Program counter of the instruction |
| res_valid | output | 1 | Result valid |
| res_kind | output | 2 | 0 immediate, 1 register, 2 memory |
| res_addr | output | 32 | Effective address for memory kind, else 0 |
| res_value | output | 32 | Immediate value or register content, else 0 |
| wb_en | output | 1 | Pointer write-back request |
| wb_idx | output | 4 | Register to write back |
| wb_value | output | 32 | Updated pointer value |

## Verification
The block holds no state beyond one result register stage. Any wrong decode, adder carry or step selection therefore shows at the ports in the single cycle after the offending input. Nothing carries over to later results, so every fault is caught by the transaction that triggers it. The sweep crosses every mode with every size code and with register and constant values next to the 32-bit wrap points and the constant's sign boundary. This exposes sign-extension and carry faults and swapped pre/post update order directly on `res_addr` and `wb_value`.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        MD_IMM  = 3'd0,
        MD_REG  = 3'd1,
        MD_ABS  = 3'd2,
        MD_IND  = 3'd3,
        MD_IDX  = 3'd4,
        MD_AINC = 3'd5,
        MD_ADEC = 3'd6,
        MD_REL  = 3'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        OK_IMM = 2'd0,
        OK_REG = 2'd1,
        OK_MEM = 2'd2
    } opnd_kind_e;

endpackage

// File: rtl/ea_step_dec.sv
module ea_step_dec #(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        size_code,
    output logic [ADDR_W-1:0] step
);
    // Step width in bytes; code 3 falls back to the widest step (R11).
    always_comb begin
        case (size_code)
            2'd0:    step = ADDR_W'(1);
            2'd1:    step = ADDR_W'(2);
            default: step = ADDR_W'(4);
        endcase
    end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [IMM_W-1:0]  konst,
    input  logic [ADDR_W-1:0] step,
    output opnd_kind_e        kind,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] value,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_val
);
    logic [ADDR_W-1:0] konst_x;

    generate
        if (ADDR_W > IMM_W) begin : g_sext
            assign konst_x = {{(ADDR_W-IMM_W){konst[IMM_W-1]}}, konst};
        end else begin : g_trunc
            assign konst_x = konst[ADDR_W-1:0];
        end
    endgenerate

    logic [ADDR_W-1:0] sum_base_k;
    logic [ADDR_W-1:0] sum_pc_k;
    logic [ADDR_W-1:0] ptr_up;
    logic [ADDR_W-1:0] ptr_dn;

    assign sum_base_k = base + konst_x;
    assign sum_pc_k   = pc_val + konst_x;
    assign ptr_up     = base + step;
    assign ptr_dn     = base - step;

    always_comb begin
        kind   = OK_MEM;
        addr   = '0;
        value  = '0;
        wb_req = 1'b0;
        wb_val = '0;
        case (ea_mode_e'(mode))
            MD_IMM: begin
                kind  = OK_IMM;
                value = konst_x;
            end
            MD_REG: begin
                kind  = OK_REG;
                value = base;
            end
            MD_ABS:  addr = konst_x;
            MD_IND:  addr = base;
            MD_IDX:  addr = sum_base_k;
            MD_AINC: begin
                addr   = base;
                wb_req = 1'b1;
                wb_val = ptr_up;
            end
            MD_ADEC: begin
                addr   = ptr_dn;
                wb_req = 1'b1;
                wb_val = ptr_dn;
            end
            MD_REL:  addr = sum_pc_k;
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/operand_ea_gen.sv
module operand_ea_gen
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int NREGS  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [2:0]               in_mode,
    input  logic [$clog2(NREGS)-1:0] in_reg,
    input  logic [IMM_W-1:0]         in_const,
    input  logic [1:0]               op_size,
    input  logic [ADDR_W-1:0]        reg_rdata,
    input  logic [ADDR_W-1:0]        pc,
    output logic                     res_valid,
    output logic [1:0]               res_kind,
    output logic [ADDR_W-1:0]        res_addr,
    output logic [ADDR_W-1:0]        res_value,
    output logic                     wb_en,
    output logic [$clog2(NREGS)-1:0] wb_idx,
    output logic [ADDR_W-1:0]        wb_value
);
    localparam int RIDX_W = $clog2(NREGS);

    typedef struct packed {
        logic              vld;
        opnd_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] value;
        logic              wb;
        logic [RIDX_W-1:0] widx;
        logic [ADDR_W-1:0] wval;
    } res_t;

    logic [ADDR_W-1:0] step_w;
    opnd_kind_e        kind_w;
    logic [ADDR_W-1:0] addr_w;
    logic [ADDR_W-1:0] value_w;
    logic              wbreq_w;
    logic [ADDR_W-1:0] wbval_w;

    ea_step_dec #(.ADDR_W(ADDR_W)) step_i (
        .size_code (op_size),
        .step      (step_w)
    );

    ea_addr_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) calc_i (
        .mode   (in_mode),
        .base   (reg_rdata),
        .pc_val (pc),
        .konst  (in_const),
        .step   (step_w),
        .kind   (kind_w),
        .addr   (addr_w),
        .value  (value_w),
        .wb_req (wbreq_w),
        .wb_val (wbval_w)
    );

    res_t res_d, res_q;

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        res_d.wb  = 1'b0;
        if (in_valid) begin
            res_d.kind  = kind_w;
            res_d.addr  = addr_w;
            res_d.value = value_w;
            res_d.wb    = wbreq_w;
            res_d.widx  = in_reg;
            res_d.wval  = wbval_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.vld;
    assign res_kind  = res_q.kind;
    assign res_addr  = res_q.addr;
    assign res_value = res_q.value;
    assign wb_en     = res_q.wb;
    assign wb_idx    = res_q.widx;
    assign wb_value  = res_q.wval;

    // R2: idle input gives idle output next cycle
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !wb_en));

    // R12: write-back only alongside a memory result
    a_r12_wb_with_mem: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (res_valid && res_kind == 2'd2));

    // R8: post-increment writes back the address plus the step
    a_r8_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 3'd5) |=>
            (wb_en && wb_value == res_addr + $past(step_w)));

    // R9: pre-decrement writes back exactly the address used
    a_r9_pre_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 3'd6) |=> (wb_en && wb_value == res_addr));

    // R13: write-back targets the register that was named
    a_r13_wb_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mode == 3'd5 || in_mode == 3'd6)) |=>
            (wb_idx == $past(in_reg)));

    // R3: immediate and register kinds carry no address
    a_r3_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind != 2'd2) |-> (res_addr == '0 && !wb_en));
endmodule

// File: tb/operand_ea_gen_tb_top.sv
module operand_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_mode;
    logic [3:0]  in_reg;
    logic [15:0] in_const;
    logic [1:0]  op_size;
    logic [31:0] reg_rdata;
    logic [31:0] pc;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [31:0] res_addr;
    logic [31:0] res_value;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_value;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    operand_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_reg(in_reg), .in_const(in_const), .op_size(op_size),
        .reg_rdata(reg_rdata), .pc(pc), .res_valid(res_valid),
        .res_kind(res_kind), .res_addr(res_addr), .res_value(res_value),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_value(wb_value)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        automatic logic [31:0] regv [4] = '{32'h0000_0000, 32'h0000_0001,
                                          32'hFFFF_FFFE, 32'h7FFF_FFFF};
        automatic logic [15:0] kv [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
        rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_reg = '0;
        in_const = '0; op_size = '0; reg_rdata = '0; pc = '0;
        repeat (3) @(negedge clk);
        chk("R1", "valid", {31'd0, res_valid}, 0);
        chk("R1", "wb_en", {31'd0, wb_en}, 0);
        chk("R1", "addr", res_addr, 0);
        chk("R1", "value", res_value, 0);
        chk("R1", "wb_value", wb_value, 0);
        rst_n = 1'b1;
        for (int m = 0; m < 8; m++)
        for (int s = 0; s < 4; s++)
        for (int r = 0; r < 4; r++)
        for (int k = 0; k < 4; k++) begin
            logic [31:0] sx, st, e_addr, e_val, e_wv;
            logic [1:0]  e_kind;
            logic        e_wb;
            in_valid  = 1'b1;
            in_mode   = 3'(m);
            in_reg    = 4'(r * 5 + k);
            in_const  = kv[k];
            op_size   = 2'(s);
            reg_rdata = regv[r];
            pc        = regv[(r + k) % 4] ^ 32'h0000_1000;
            sx = {{16{kv[k][15]}}, kv[k]};
            st = (s == 0) ? 32'd1 : (s == 1) ? 32'd2 : 32'd4;   // R11
            e_kind = 2'd2; e_addr = 0; e_val = 0; e_wb = 0; e_wv = 0;
            case (m)
                0: begin e_kind = 2'd0; e_val = sx; end          // R3
                1: begin e_kind = 2'd1; e_val = regv[r]; end     // R4
                2: e_addr = sx;                                   // R5
                3: e_addr = regv[r];                              // R6
                4: e_addr = regv[r] + sx;                         // R7
                5: begin e_addr = regv[r]; e_wb = 1; e_wv = regv[r] + st; end  // R8
                6: begin e_addr = regv[r] - st; e_wb = 1; e_wv = regv[r] - st; end // R9
                default: e_addr = pc + sx;                        // R10
            endcase
            @(negedge clk);
            chk("R2", "valid", {31'd0, res_valid}, 1);
            chk("R3-kind", "kind", {30'd0, res_kind}, {30'd0, e_kind});
            chk((m == 4) ? "R7" : (m == 7) ? "R10" : (m == 6) ? "R9" : "R5",
                "addr", res_addr, e_addr);
            chk("R13", "value", res_value, e_val);
            chk("R12", "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
            if (e_wb) begin
                chk(m == 5 ? "R8" : "R9", "wb_value", wb_value, e_wv);
                chk("R13", "wb_idx", {28'd0, wb_idx}, {28'd0, in_reg});
                chk("R11", "step", (m == 5) ? wb_value - regv[r] : regv[r] - wb_value, st);
            end
            if ((m + s + r + k) % 7 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk("R2", "idle valid", {31'd0, res_valid}, 0);
                chk("R12", "idle wb_en", {31'd0, wb_en}, 0);
            end
        end
        in_valid = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule